// File: doc/BRIEF.md
# Flash Chip-Select Timing Controller

This block owns the active-low chip select of a serial flash port. It accepts a transaction request, lowers chip select, and waits out a programmable setup interval before it allows the serial clock generator to start. When the shift sequencer reports that the last rising serial clock edge has occurred, the block stops the clock and keeps chip select low for a programmable hold interval. It then releases chip select and enforces a minimum high time before the next command can begin.

After an access, chip select can optionally stay low for an extension window of 32 or 128 serial clock cycles, or indefinitely. During that window a request whose start address continues the previous access proceeds at once, without chip select going high. A request that jumps elsewhere closes the window, waits out the minimum high time, and then starts on its own. All intervals are counted in system clock cycles from the serial clock divide ratio `div_i`. Half a serial cycle is `div_i/2` system cycles.

Top module: `flash_cs_timing`

## Requirements
- R1: After reset `cs_no` is 1, `sck_en_o` is 0 and `ready_o` is 1.
- R2: `sck_en_o` rises exactly S system cycles after `cs_no` falls, with S = div_i/2 when `setup_long_i`=0 and S = 3*div_i/2 when it is 1.
- R3: In the cycle after the one where `done_i` is seen high while `sck_en_o` is high, `sck_en_o` goes low. `cs_no` rises exactly H cycles after that fall, with H = div_i/2 when `hold_long_i`=0 and H = 3*div_i/2 when it is 1.
- R4: A request is accepted on a clock edge where `req_i` and `ready_o` are both high, and `cs_no` is low in the following cycle. With `ext_mode_i`=00, `cs_no` stays high for exactly M = (idle_i+1)*div_i cycles between back-to-back commands. `ready_o` is high only in the last of those cycles.
- R5: With `ext_mode_i`=01 or 10, `cs_no` stays low for H+32*div_i or H+128*div_i cycles after `sck_en_o` falls, and `ready_o` is high during the extension.
- R6: With `ext_mode_i`=11, `cs_no` stays low indefinitely after an access while no request arrives.
- R7: A request accepted during the extension whose `req_addr_i` equals the previous accepted `req_addr_i` plus `req_len_i` raises `sck_en_o` in the next cycle, and `cs_no` does not go high.
- R8: Any other request accepted during the extension raises `cs_no` in the next cycle and holds it high for M cycles with `ready_o` low. `cs_no` then falls without a new request, and `sck_en_o` follows S cycles later.
- R9: `req_i` while `ready_o` is low, and `done_i` while `sck_en_o` is low, have no effect on `cs_no`, `sck_en_o` or `ready_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Transaction request, held until accepted |
| req_addr_i | input | ADDR_W | Start address of the requested access |
| req_len_i | input | LEN_W | Length of the requested access in address units |
| done_i | input | 1 | Sequencer reports the last rising serial clock edge |
| div_i | input | DIV_W | Serial clock divide ratio, even, 2 to 64 |
| setup_long_i | input | 1 | 0: setup 0.5 serial cycle, 1: 1.5 serial cycles |
| hold_long_i | input | 1 | 0: hold 0.5 serial cycle, 1: 1.5 serial cycles |
| idle_i | input | IDLE_W | Minimum chip-select high time minus one, in serial cycles |
| ext_mode_i | input | 2 | Extension: 00 none, 01 32 cycles, 10 128 cycles, 11 unlimited |
| cs_no | output | 1 | Active-low chip select |
| sck_en_o | output | 1 | Permission for the clock generator to toggle |
| ready_o | output | 1 | A request can be accepted on the next edge |

## Verification
The bench uses the default parameters (7-bit divider, 4-bit idle field). This lets it sweep divide ratios 2, 4 and 6 against both setup settings, both hold settings and four idle values, and check every interval against arithmetic on those settings. Extension windows are measured at a divide ratio of 4, which brings the full 128-cycle window and the unlimited mode into a short run. Contiguous and non-contiguous follow-on requests are both driven into an open window.

// File: rtl/fcs_pkg.sv
package fcs_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_SETUP, ST_ACTIVE, ST_HOLD, ST_EXT, ST_GAP
  } fcs_state_e;

  localparam logic [1:0] EXT_NONE = 2'b00;
  localparam logic [1:0] EXT_32   = 2'b01;
  localparam logic [1:0] EXT_128  = 2'b10;
  localparam logic [1:0] EXT_INF  = 2'b11;
endpackage

// File: rtl/fcs_span_calc.sv
module fcs_span_calc #(
  parameter int DIV_W  = 7,
  parameter int IDLE_W = 4,
  parameter int CNT_W  = 14
) (
  input  logic [DIV_W-1:0]  div_i,
  input  logic              setup_long_i,
  input  logic              hold_long_i,
  input  logic [IDLE_W-1:0] idle_i,
  input  logic [1:0]        ext_mode_i,
  output logic [CNT_W-1:0]  setup_len_o,
  output logic [CNT_W-1:0]  hold_len_o,
  output logic [CNT_W-1:0]  idle_len_o,
  output logic [CNT_W-1:0]  ext_len_o
);
  import fcs_pkg::*;

  logic [CNT_W-1:0] half, full, half3;

  assign full  = CNT_W'(div_i);
  assign half  = CNT_W'(div_i[DIV_W-1:1]);
  assign half3 = (half << 1) + half;

  assign setup_len_o = setup_long_i ? half3 : half;
  assign hold_len_o  = hold_long_i  ? half3 : half;
  assign idle_len_o  = (CNT_W'(idle_i) + CNT_W'(1)) * full;
  assign ext_len_o   = (ext_mode_i == EXT_32) ? (full << 5) : (full << 7);
endmodule

// File: rtl/fcs_down_cnt.sv
module fcs_down_cnt #(
  parameter int CNT_W = 14
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic             zero_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       cnt_q <= '0;
    else if (load_i)   cnt_q <= load_val_i;
    else if (!zero_o)  cnt_q <= cnt_q - CNT_W'(1);
  end

  assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/fcs_seq_track.sv
module fcs_seq_track #(
  parameter int ADDR_W = 24,
  parameter int LEN_W  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              accept_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [LEN_W-1:0]  req_len_i,
  output logic              contig_o
);
  logic [ADDR_W-1:0] next_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        next_q <= '0;
    else if (accept_i)  next_q <= req_addr_i + ADDR_W'(req_len_i);
  end

  assign contig_o = (req_addr_i == next_q);
endmodule

// File: rtl/flash_cs_timing.sv
module flash_cs_timing #(
  parameter int ADDR_W = 24,
  parameter int LEN_W  = 8,
  parameter int DIV_W  = 7,
  parameter int IDLE_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [LEN_W-1:0]  req_len_i,
  input  logic              done_i,
  input  logic [DIV_W-1:0]  div_i,
  input  logic              setup_long_i,
  input  logic              hold_long_i,
  input  logic [IDLE_W-1:0] idle_i,
  input  logic [1:0]        ext_mode_i,
  output logic              cs_no,
  output logic              sck_en_o,
  output logic              ready_o
);
  import fcs_pkg::*;

  localparam int CNT_W = DIV_W + 7 + ((IDLE_W > 7) ? IDLE_W - 7 : 0);

  fcs_state_e       st_q, st_d;
  logic             pend_q, pend_d;
  logic             ld, zero, accept, contig;
  logic [CNT_W-1:0] ld_val;
  logic [CNT_W-1:0] setup_len, hold_len, idle_len, ext_len;
  logic             cs_q, sck_q;

  fcs_span_calc #(.DIV_W(DIV_W), .IDLE_W(IDLE_W), .CNT_W(CNT_W)) u_span (
    .div_i(div_i), .setup_long_i(setup_long_i), .hold_long_i(hold_long_i),
    .idle_i(idle_i), .ext_mode_i(ext_mode_i),
    .setup_len_o(setup_len), .hold_len_o(hold_len),
    .idle_len_o(idle_len), .ext_len_o(ext_len)
  );

  fcs_down_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(ld), .load_val_i(ld_val), .zero_o(zero)
  );

  fcs_seq_track #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_seq (
    .clk_i(clk_i), .rst_ni(rst_ni), .accept_i(accept),
    .req_addr_i(req_addr_i), .req_len_i(req_len_i), .contig_o(contig)
  );

  assign ready_o = (st_q == ST_IDLE) || (st_q == ST_EXT) ||
                   ((st_q == ST_GAP) && zero && !pend_q);

  always_comb begin
    st_d   = st_q;
    pend_d = pend_q;
    ld     = 1'b0;
    ld_val = '0;
    accept = 1'b0;
    unique case (st_q)
      ST_IDLE: if (req_i) begin
        accept = 1'b1;
        st_d   = ST_SETUP;
        ld     = 1'b1;
        ld_val = setup_len - CNT_W'(1);
      end
      ST_SETUP: if (zero) st_d = ST_ACTIVE;
      ST_ACTIVE: if (done_i) begin
        st_d   = ST_HOLD;
        ld     = 1'b1;
        ld_val = hold_len - CNT_W'(1);
      end
      ST_HOLD: if (zero) begin
        ld = 1'b1;
        if (ext_mode_i == EXT_NONE) begin
          st_d   = ST_GAP;
          ld_val = idle_len - CNT_W'(1);
        end else begin
          st_d   = ST_EXT;
          ld_val = ext_len - CNT_W'(1);
        end
      end
      ST_EXT: begin
        if (req_i) begin
          accept = 1'b1;
          if (contig) st_d = ST_ACTIVE;
          else begin
            // jump elsewhere: close window, start after the idle gap
            st_d   = ST_GAP;
            pend_d = 1'b1;
            ld     = 1'b1;
            ld_val = idle_len - CNT_W'(1);
          end
        end else if (zero && ext_mode_i != EXT_INF) begin
          st_d   = ST_GAP;
          ld     = 1'b1;
          ld_val = idle_len - CNT_W'(1);
        end
      end
      ST_GAP: if (zero) begin
        if (pend_q || req_i) begin
          accept = !pend_q;
          pend_d = 1'b0;
          st_d   = ST_SETUP;
          ld     = 1'b1;
          ld_val = setup_len - CNT_W'(1);
        end else st_d = ST_IDLE;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      pend_q <= 1'b0;
      cs_q   <= 1'b1;
      sck_q  <= 1'b0;
    end else begin
      st_q   <= st_d;
      pend_q <= pend_d;
      cs_q   <= !(st_d inside {ST_SETUP, ST_ACTIVE, ST_HOLD, ST_EXT});
      sck_q  <= (st_d == ST_ACTIVE);
    end
  end

  assign cs_no    = cs_q;
  assign sck_en_o = sck_q;

  assert_clk_inside_cs_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sck_en_o) |-> (!cs_no && !$past(cs_no)));

  assert_cs_after_clk_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cs_no) |-> (!sck_en_o && !$past(sck_en_o)));

  assert_accept_lowers_cs_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && ready_o && st_q != ST_EXT) |=> !cs_no);

  assert_inf_ext_holds_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_EXT && ext_mode_i == EXT_INF && !req_i) |=> !cs_no);

  assert_pending_blocks_ready_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pend_q |-> (!ready_o && cs_no));

  assert_no_done_outside_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sck_en_o && cs_no && !req_i) |=> !sck_en_o);
endmodule

// File: tb/flash_cs_timing_tb_top.sv
`timescale 1ns/1ps
module flash_cs_timing_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_i = 1'b0;
  logic [23:0] req_addr_i = '0;
  logic [7:0]  req_len_i = '0;
  logic        done_i = 1'b0;
  logic [6:0]  div_i = 7'd2;
  logic        setup_long_i = 1'b0, hold_long_i = 1'b0;
  logic [3:0]  idle_i = '0;
  logic [1:0]  ext_mode_i = '0;
  logic        cs_no, sck_en_o, ready_o;

  always #2.5 clk = ~clk;

  flash_cs_timing dut_i (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req_i), .req_addr_i(req_addr_i),
    .req_len_i(req_len_i), .done_i(done_i), .div_i(div_i),
    .setup_long_i(setup_long_i), .hold_long_i(hold_long_i), .idle_i(idle_i),
    .ext_mode_i(ext_mode_i), .cs_no(cs_no), .sck_en_o(sck_en_o), .ready_o(ready_o)
  );

  int cyc = 0;
  int n_chk = 0, n_bad = 0;
  int t_csf, t_csr, t_sckr, t_sckf, acc_cyc, rdy_hi;
  logic prev_cs = 1'b1, prev_sck = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (rst_n) begin
      if (prev_cs && !cs_no) t_csf = cyc;
      if (!prev_cs && cs_no) t_csr = cyc;
      if (!prev_sck && sck_en_o) t_sckr = cyc;
      if (prev_sck && !sck_en_o) t_sckf = cyc;
      if (ready_o && cs_no) rdy_hi++;
      prev_cs  = cs_no;
      prev_sck = sck_en_o;
    end
  end

  task automatic step();
    @(negedge clk);
    #1;
  endtask

  task automatic chk(input string r, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d (div=%0d sl=%0d hl=%0d idle=%0d ext=%0d)",
               r, act, exp, div_i, setup_long_i, hold_long_i, idle_i, ext_mode_i);
    end
  endtask

  task automatic do_req(input int a, input int l);
    req_addr_i = 24'(a);
    req_len_i  = 8'(l);
    req_i      = 1'b1;
    while (!ready_o) step();
    step();
    acc_cyc = cyc;
    req_i   = 1'b0;
  endtask

  task automatic wait_sck();
    while (!sck_en_o) step();
  endtask

  task automatic pulse_done();
    done_i = 1'b1;
    step();
    done_i = 1'b0;
  endtask

  task automatic settle();
    while (!(cs_no && ready_o)) step();
    step(); step();
  endtask

  function automatic int half_n(input int d, input bit lng);
    return lng ? 3 * (d / 2) : d / 2;
  endfunction

  task automatic run_all();
    int s, h, m, csr_keep, csf_keep;
    rst_n = 1'b0;
    step(); step();
    rst_n = 1'b1;
    step();
    chk("R1 cs_no", int'(cs_no), 1);
    chk("R1 sck_en", int'(sck_en_o), 0);
    chk("R1 ready", int'(ready_o), 1);

    // sweep: setup, hold, idle gap with back-to-back commands
    for (int d = 2; d <= 6; d += 2)
      for (int sl = 0; sl < 2; sl++)
        for (int hl = 0; hl < 2; hl++)
          for (int id = 0; id < 4; id++) begin
            div_i = 7'(d); setup_long_i = sl[0]; hold_long_i = hl[0];
            idle_i = 4'(id); ext_mode_i = 2'b00;
            s = half_n(d, sl[0]); h = half_n(d, hl[0]); m = (id + 1) * d;
            do_req(16'h100, 4);
            chk("R4 cs falls after accept", t_csf, acc_cyc);
            wait_sck();
            chk("R2 setup", t_sckr - t_csf, s);
            step(); step(); step();
            pulse_done();
            do_req(16'h900, 4);
            chk("R3 clk stops after done", t_sckf, acc_cyc - h - m);
            chk("R3 hold", t_csr - t_sckf, h);
            chk("R4 idle gap", t_csf - t_csr, m);
            wait_sck();
            chk("R2 setup second", t_sckr - t_csf, s);
            pulse_done();
            settle();
          end

    // extension windows of 32 and 128 serial cycles
    div_i = 7'd4; setup_long_i = 1'b0; hold_long_i = 1'b0; idle_i = 4'd1;
    for (int e = 1; e <= 2; e++) begin
      ext_mode_i = 2'(e);
      h = 2;
      do_req(16'h200, 8);
      wait_sck();
      step();
      pulse_done();
      for (int k = 0; k < h; k++) step();
      chk("R5 ready in window", int'(ready_o), 1);
      chk("R5 cs low in window", int'(cs_no), 0);
      while (!cs_no) step();
      chk("R5 window length", t_csr - t_sckf, h + ((e == 1) ? 32 : 128) * 4);
      settle();
    end

    // unlimited extension, contiguous then non-contiguous follow-on
    ext_mode_i = 2'b11; m = 2 * 4; s = 2; h = 2;
    do_req(16'h400, 16);
    wait_sck();
    pulse_done();
    csr_keep = t_csr;
    for (int k = 0; k < 700; k++) step();
    chk("R6 cs held", int'(cs_no), 0);
    chk("R6 ready held", int'(ready_o), 1);
    do_req(16'h410, 8);
    chk("R7 clk restarts next cycle", t_sckr, acc_cyc);
    chk("R7 sck_en", int'(sck_en_o), 1);
    chk("R7 cs never released", t_csr, csr_keep);
    pulse_done();
    for (int k = 0; k < h; k++) step();
    do_req(16'h800, 8);
    rdy_hi = 0;
    chk("R8 window closes", t_csr, acc_cyc);
    wait_sck();
    chk("R8 idle gap", t_csf - t_csr, m);
    chk("R8 setup after gap", t_sckr - t_csf, s);
    chk("R8 ready low in gap", rdy_hi, 0);
    ext_mode_i = 2'b00;
    pulse_done();
    settle();

    // ignored stimulus
    div_i = 7'd2; idle_i = 4'd0; m = 2;
    do_req(16'h10, 1);
    wait_sck();
    csf_keep = t_csf;
    req_addr_i = 24'h55; req_i = 1'b1;
    step();
    req_i = 1'b0;
    chk("R9 req ignored while busy sck", int'(sck_en_o), 1);
    chk("R9 req ignored while busy cs", int'(cs_no), 0);
    pulse_done();
    for (int k = 0; k < 4 * m + 6; k++) step();
    chk("R9 no stray transaction", t_csf, csf_keep);
    chk("R9 cs high", int'(cs_no), 1);
    pulse_done();
    step(); step();
    chk("R9 done ignored cs", int'(cs_no), 1);
    chk("R9 done ignored sck", int'(sck_en_o), 0);
    chk("R9 done ignored ready", int'(ready_o), 1);
  endtask

  initial begin
    fork
      run_all();
      begin
        repeat (150000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule